// File: doc/BRIEF.md
# Length-Framed Bus Frame Receiver

This block collects frames from a shared serial bus. A byte-level UART receiver in front of it delivers one byte per `rx_valid` pulse along with framing, parity and overrun flags. An active-low attention line shared by all bus nodes marks a frame in progress. When that line falls while the block is idle, the block opens a frame. It stores the incoming bytes in an internal buffer that can be inferred as block RAM. The frame length is taken from the second byte. When the frame is complete, the block holds it and raises `frame_ready` until the consumer reads the buffer through a synchronous read port and pulses `frame_ack`.

Any error discards the frame. The block then ignores all bus traffic until the attention line is seen high again. Four saturating counters record I/O errors, bytes that arrived with no buffer available, oversize frames and delivered frames. A per-state dwell counter lets surrounding logic apply its own timeouts. CRC checking is left to the consumer.

Top module: `lenframe_rx`

## Requirements
- R1: A frame is opened only by a high-to-low transition of the synchronized attention line seen while the state is idle. The `state_o` codes are: idle = 0, reading = 1, skipping = 2, ready = 3. A line that is already low when the block returns to idle does not open a frame.
- R2: Byte 0 is the destination address and byte 1 is the payload length L. A good frame holds L+3 bytes (address, length, payload, one check byte). These are stored at buffer addresses 0 upward. `frame_len` reports the count of stored bytes, and `rd_data` returns the byte at `rd_addr` one cycle later.
- R3: A frame has DEPTH-1 bytes of space. When byte 1 arrives, L+1 must be strictly less than the space still free (DEPTH-3). Otherwise the size counter increments and the state becomes skipping. When the free space reaches zero, the frame is complete.
- R4: A byte that carries any of the framing, parity or overrun flags increments the I/O counter and moves the block to skipping. This applies in idle, reading or ready.
- R5: A clean byte that arrives in idle or ready increments the no-buffer counter and moves the block to skipping. In skipping, every byte is ignored and no counter changes.
- R6: On completion the state becomes ready and `frame_ready` is 1. The block stays there until `frame_ack`. The acknowledge returns it to idle and increments the packets counter. An acknowledge outside ready has no effect.
- R7: The skipping state is left, always to idle, only when the synchronized attention line is high.
- R8: All four event counters are CNT_W bits wide (default 16) and stop at all ones instead of wrapping.
- R9: `dwell` is 0 in the cycle after any state change. It counts up by one per cycle in a steady state and holds at 255.
- R10: `attn_n` passes through two synchronizer flops. A fall driven before clock edge k is first visible in `state_o` after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| attn_n | input | 1 | Shared attention line, active low, asynchronous |
| rx_valid | input | 1 | One received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| rx_ferr | input | 1 | Framing error flag for the byte |
| rx_perr | input | 1 | Parity error flag for the byte |
| rx_oerr | input | 1 | Overrun flag for the byte |
| frame_ack | input | 1 | Consumer has taken the frame |
| rd_addr | input | AW | Buffer read address |
| rd_data | output | 8 | Buffer byte, registered |
| frame_ready | output | 1 | A complete frame is held |
| frame_len | output | LW | Bytes stored in the current frame |
| cnt_io | output | CNT_W | Flagged-byte counter |
| cnt_nobuf | output | CNT_W | No-buffer counter |
| cnt_size | output | CNT_W | Oversize counter |
| cnt_pkts | output | CNT_W | Delivered frame counter |
| state_o | output | 2 | Current state code |
| dwell | output | 8 | Cycles spent in the current state |

## Verification
A byte driven for one cycle changes the state, the counters and `frame_len` at the very next edge. An attention change needs three edges because of the two synchronizer flops and the edge detector. A buffer read returns data one edge after the address is applied. The bench drives every input at the falling clock edge and samples at the following falling edge, stepping exactly one, two or three cycles according to these latencies. A separate monitor takes the expected frames from a queue only when `frame_ready` is seen, so frame checks do not depend on how long the driver takes.

// File: rtl/lfr_pkg.sv
package lfr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_SKIP  = 2'd2,
    ST_READY = 2'd3
  } lfr_state_e;

  localparam int NCNT     = 4;
  localparam int CI_IO    = 0;
  localparam int CI_NOBUF = 1;
  localparam int CI_SIZE  = 2;
  localparam int CI_PKT   = 3;

  localparam int DWELL_W  = 8;
endpackage

// File: rtl/lfr_sync.sv
module lfr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lfr_buffer.sv
module lfr_buffer #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/lfr_satcnt.sv
module lfr_satcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)                   cnt <= '0;
    else if (inc && cnt != '1) cnt <= cnt + W'(1);
  end

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cnt == '1) |=> (cnt == '1)); // R8

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (cnt != $past(cnt)) |-> (cnt == $past(cnt) + W'(1))); // R8
endmodule

// File: rtl/lfr_dwell.sv
module lfr_dwell #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  output logic [W-1:0] dwell
);
  always_ff @(posedge clk) begin
    if (rst || restart)    dwell <= '0;
    else if (dwell != '1)  dwell <= dwell + W'(1);
  end

  AST_DWELL_SAT: assert property (@(posedge clk) disable iff (rst)
    (dwell == '1 && !restart) |=> (dwell == '1)); // R9
endmodule

// File: rtl/lfr_ctrl.sv
module lfr_ctrl
  import lfr_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1),
  localparam int NW = (LW > 9) ? LW : 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            attn_s,
  input  logic            rx_valid,
  input  logic [7:0]      rx_data,
  input  logic            rx_bad,
  input  logic            frame_ack,
  output logic            wr_en,
  output logic [AW-1:0]   wr_addr,
  output lfr_state_e      state_q,
  output logic            state_chg,
  output logic [LW-1:0]   used_q,
  output logic [NCNT-1:0] inc
);
  lfr_state_e    state_d;
  logic [LW-1:0] used_d;
  logic [NW-1:0] left_q, left_d, left_dec, need;
  logic          attn_prev, fall;

  assign fall     = attn_prev & ~attn_s;
  assign left_dec = left_q - NW'(1);
  assign need     = NW'(rx_data) + NW'(1);
  assign wr_addr  = used_q[AW-1:0];

  always_comb begin
    state_d = state_q;
    used_d  = used_q;
    left_d  = left_q;
    wr_en   = 1'b0;
    inc     = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (rx_valid) begin
          state_d = ST_SKIP;
          if (rx_bad) inc[CI_IO]    = 1'b1;
          else        inc[CI_NOBUF] = 1'b1;
        end else if (fall) begin
          state_d = ST_READ;
          used_d  = '0;
          left_d  = NW'(DEPTH - 1);
        end
      end
      ST_READ: begin
        if (rx_valid) begin
          if (rx_bad) begin
            inc[CI_IO] = 1'b1;
            state_d    = ST_SKIP;
          end else begin
            wr_en  = 1'b1;
            used_d = used_q + LW'(1);
            left_d = left_dec;
            if (left_dec == '0) begin
              state_d = ST_READY;
            end else if (used_q == LW'(1)) begin
              if (need >= left_dec) begin
                inc[CI_SIZE] = 1'b1;
                state_d      = ST_SKIP;
              end else begin
                left_d = need;
              end
            end
          end
        end
      end
      ST_SKIP: begin
        if (attn_s) state_d = ST_IDLE;
      end
      ST_READY: begin
        if (rx_valid) begin
          state_d = ST_SKIP;
          if (rx_bad) inc[CI_IO]    = 1'b1;
          else        inc[CI_NOBUF] = 1'b1;
        end else if (frame_ack) begin
          state_d     = ST_IDLE;
          inc[CI_PKT] = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign state_chg = (state_d != state_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      used_q    <= '0;
      left_q    <= '0;
      attn_prev <= 1'b1;
    end else begin
      state_q   <= state_d;
      used_q    <= used_d;
      left_q    <= left_d;
      attn_prev <= attn_s;
    end
  end

  AST_READ_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_READ && $past(state_q) != ST_READ)
      |-> ($past(state_q) == ST_IDLE && $past(fall))); // R1

  AST_SKIP_LEAVE: assert property (@(posedge clk) disable iff (rst)
    ($past(state_q) == ST_SKIP && state_q != ST_SKIP)
      |-> (state_q == ST_IDLE && $past(attn_s))); // R7

  AST_READY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_READY && !frame_ack && !rx_valid) |=> (state_q == ST_READY)); // R6

  AST_SPACE_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_READ) |-> (left_q != '0 && used_q < LW'(DEPTH))); // R3

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(inc)); // R8
endmodule

// File: rtl/lenframe_rx.sv
module lenframe_rx
  import lfr_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CNT_W = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             attn_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_ferr,
  input  logic             rx_perr,
  input  logic             rx_oerr,
  input  logic             frame_ack,
  input  logic [AW-1:0]    rd_addr,
  output logic [7:0]       rd_data,
  output logic             frame_ready,
  output logic [LW-1:0]    frame_len,
  output logic [CNT_W-1:0] cnt_io,
  output logic [CNT_W-1:0] cnt_nobuf,
  output logic [CNT_W-1:0] cnt_size,
  output logic [CNT_W-1:0] cnt_pkts,
  output logic [1:0]       state_o,
  output logic [7:0]       dwell
);
  logic            attn_s;
  logic            wr_en, state_chg;
  logic [AW-1:0]   wr_addr;
  lfr_state_e      state_q;
  logic [NCNT-1:0] inc;
  logic [CNT_W-1:0] cnt_arr [NCNT];

  lfr_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(attn_n), .q(attn_s)
  );

  lfr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .attn_s(attn_s),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_bad(rx_ferr | rx_perr | rx_oerr),
    .frame_ack(frame_ack),
    .wr_en(wr_en), .wr_addr(wr_addr),
    .state_q(state_q), .state_chg(state_chg),
    .used_q(frame_len), .inc(inc)
  );

  lfr_buffer #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(rx_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    lfr_satcnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .inc(inc[g]), .cnt(cnt_arr[g])
    );
  end

  lfr_dwell #(.W(DWELL_W)) u_dwell (
    .clk(clk), .rst(rst), .restart(state_chg), .dwell(dwell)
  );

  assign cnt_io      = cnt_arr[CI_IO];
  assign cnt_nobuf   = cnt_arr[CI_NOBUF];
  assign cnt_size    = cnt_arr[CI_SIZE];
  assign cnt_pkts    = cnt_arr[CI_PKT];
  assign state_o     = state_q;
  assign frame_ready = (state_q == ST_READY);

  AST_DWELL_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (state_q != $past(state_q)) |-> (dwell == '0)); // R9

  AST_PKT_ON_ACK: assert property (@(posedge clk) disable iff (rst)
    (cnt_pkts != $past(cnt_pkts)) |-> ($past(state_q) == ST_READY && $past(frame_ack))); // R6
endmodule

// File: tb/test_lenframe_rx.sv
module test_lenframe_rx;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;
  localparam int AW = 5;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst, attn_n, rx_valid, rx_ferr, rx_perr, rx_oerr, frame_ack;
  logic [7:0] rx_data, rd_data;
  logic [AW-1:0] rd_addr;
  logic frame_ready;
  logic [5:0] frame_len;
  logic [CW-1:0] cnt_io, cnt_nobuf, cnt_size, cnt_pkts;
  logic [1:0] state_o;
  logic [7:0] dwell;

  int n_chk = 0, n_fail = 0, frames_seen = 0;
  bit hold_ack = 1'b0;
  int  len_q[$];
  byte unsigned byte_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lenframe_rx #(.DEPTH(DEPTH), .CNT_W(CW)) i_lenframe_rx (
    .clk(clk), .rst(rst), .attn_n(attn_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ferr(rx_ferr), .rx_perr(rx_perr), .rx_oerr(rx_oerr), .frame_ack(frame_ack),
    .rd_addr(rd_addr), .rd_data(rd_data), .frame_ready(frame_ready), .frame_len(frame_len),
    .cnt_io(cnt_io), .cnt_nobuf(cnt_nobuf), .cnt_size(cnt_size), .cnt_pkts(cnt_pkts),
    .state_o(state_o), .dwell(dwell)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic send_byte(input logic [7:0] d, input logic [2:0] fl);
    rx_valid = 1'b1; rx_data = d;
    {rx_oerr, rx_perr, rx_ferr} = fl;
    @(negedge clk);
    rx_valid = 1'b0; {rx_oerr, rx_perr, rx_ferr} = 3'b000;
  endtask

  task automatic start_rx();
    attn_n = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic release_attn();
    attn_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic put_frame(input logic [7:0] a, input int len);
    byte unsigned b;
    len_q.push_back(len + 3);
    for (int i = 0; i < len + 3; i++) begin
      if (i == 0) b = a;
      else if (i == 1) b = 8'(len);
      else b = 8'(i * 37 + len);
      byte_q.push_back(b);
      send_byte(b, 3'b000);
    end
  endtask

  task automatic wait_frames(input int n);
    wait (frames_seen == n);
    @(negedge clk);
  endtask

  // monitor: scoreboard side, R2 and R6
  initial begin
    int L;
    frame_ack = 1'b0; rd_addr = '0;
    forever begin
      @(negedge clk);
      if (frame_ready && !hold_ack && len_q.size() > 0) begin
        L = len_q.pop_front();
        chk("R2 frame_len", int'(frame_len), L);
        for (int i = 0; i < L; i++) begin
          rd_addr = AW'(i);
          @(negedge clk);
          chk("R2 stored byte", int'(rd_data), int'(byte_q.pop_front()));
        end
        frame_ack = 1'b1;
        @(negedge clk);
        frame_ack = 1'b0;
        frames_seen++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; attn_n = 1'b1; rx_valid = 1'b0; rx_data = '0;
    rx_ferr = 1'b0; rx_perr = 1'b0; rx_oerr = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R6 reset state", int'(state_o), 0);
    chk("R6 reset ready", int'(frame_ready), 0);
    chk("R8 reset io", int'(cnt_io), 0);
    chk("R8 reset pkts", int'(cnt_pkts), 0);

    // R10 synchronizer latency, R1 start on fall in idle
    attn_n = 1'b0;
    @(negedge clk); chk("R10 edge1", int'(state_o), 0);
    @(negedge clk); chk("R10 edge2", int'(state_o), 0);
    @(negedge clk); chk("R10 R1 edge3 reading", int'(state_o), 1);
    put_frame(8'h21, 3);
    wait_frames(1);
    chk("R6 pkts after ack", int'(cnt_pkts), 1);
    chk("R6 idle after ack", int'(state_o), 0);
    release_attn();

    // R2 zero-length payload
    start_rx(); put_frame(8'h11, 0); wait_frames(2); release_attn();
    // R3 largest accepted payload: 27+1 < 29
    start_rx(); put_frame(8'h12, 27); wait_frames(3); release_attn();
    chk("R6 pkts three", int'(cnt_pkts), 3);

    // R3 oversize: 28+1 >= 29
    start_rx();
    send_byte(8'h22, 3'b000);
    send_byte(8'd28, 3'b000);
    chk("R3 size error state", int'(state_o), 2);
    chk("R3 size counter", int'(cnt_size), 1);
    send_byte(8'h05, 3'b000);
    send_byte(8'h06, 3'b001);
    chk("R5 skip ignores nobuf", int'(cnt_nobuf), 0);
    chk("R5 skip ignores io", int'(cnt_io), 0);
    repeat (5) @(negedge clk);
    chk("R7 stays skipping while low", int'(state_o), 2);
    attn_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R7 not yet left", int'(state_o), 2);
    @(negedge clk);
    chk("R7 left to idle", int'(state_o), 0);

    // R4 parity flag mid-frame
    start_rx();
    send_byte(8'h33, 3'b000);
    send_byte(8'h04, 3'b010);
    chk("R4 io counter", int'(cnt_io), 1);
    chk("R4 skipping", int'(state_o), 2);
    chk("R4 not ready", int'(frame_ready), 0);
    release_attn();

    // R5 clean byte in idle
    send_byte(8'h44, 3'b000);
    chk("R5 nobuf counter", int'(cnt_nobuf), 1);
    chk("R5 skipping", int'(state_o), 2);
    @(negedge clk);
    chk("R7 back idle attn high", int'(state_o), 0);

    // R6 ack outside ready
    frame_ack = 1'b1; @(negedge clk); frame_ack = 1'b0;
    @(negedge clk);
    chk("R6 stray ack pkts", int'(cnt_pkts), 3);
    chk("R6 stray ack state", int'(state_o), 0);

    // R6 hold, R1 fall while not idle
    hold_ack = 1'b1;
    start_rx(); put_frame(8'h55, 2);
    chk("R6 ready", int'(frame_ready), 1);
    repeat (10) @(negedge clk);
    chk("R6 ready held", int'(state_o), 3);
    attn_n = 1'b1; repeat (3) @(negedge clk);
    attn_n = 1'b0; repeat (4) @(negedge clk);
    chk("R1 fall in ready ignored", int'(state_o), 3);
    hold_ack = 1'b0;
    wait_frames(4);
    repeat (5) @(negedge clk);
    chk("R1 low level no start", int'(state_o), 0);
    chk("R6 pkts four", int'(cnt_pkts), 4);
    release_attn();

    // R9 dwell
    repeat (300) @(negedge clk);
    chk("R9 dwell saturates", int'(dwell), 255);
    send_byte(8'h66, 3'b000);
    chk("R9 state changed", int'(state_o), 2);
    chk("R9 dwell cleared", int'(dwell), 0);
    @(negedge clk);

    // R8 saturation
    repeat (20) begin
      send_byte(8'h77, 3'b000);
      @(negedge clk);
    end
    chk("R8 nobuf saturates", int'(cnt_nobuf), 15);
    send_byte(8'h78, 3'b000);
    chk("R8 nobuf holds", int'(cnt_nobuf), 15);
    repeat (3) @(negedge clk);

    summary();
    $finish;
  end
endmodule